// File: doc/BRIEF.md
# Pixel Color Mode Decoder

This block sits between the video-memory fetch path and the display output stage of a raster pipeline. Each cycle it may accept one raw pixel word with a valid strobe and a 4-bit color mode code. From these it produces a 24-bit red/green/blue value. Depending on the mode, the pixel is handled in one of three ways. It can be used as an 8-bit index into a writable 256-entry palette of 24-bit colors. It can be taken directly as three 8-bit components. It can be unpacked from a 16-bit 5:6:5 or 5:5:5 word, with each short field widened to 8 bits.

Two blink transforms, a dim one and a bright one, act on 8-bit values while a blink phase input is high. In the blinking palette modes the transform is applied to the index before the palette is read. In the blinking direct modes it is applied to each of the three components separately.

The palette is loaded through a simple write port, which may be used at any time, even while pixels are flowing. The output is registered and always appears exactly two cycles after its input.

Top module: `pixel_decode`

## Requirements
- R1: An accepted pixel (`pixValid`=1 at a rising edge) shows up on `rgbValid`/`rgbOut` after exactly two rising edges, in every mode.
- R2: While `rst_n` is low, `rgbValid` and `rgbOut` are both 0.
- R3: Mode 4'b0000 outputs the palette entry indexed by `pixData[7:0]`. Bits 23:8 are ignored.
- R4: A palette write (`palWrEn`=1) stores `palWrData` at `palWrAddr` at the rising edge. A pixel that reads the same entry at that same edge gets the old value. Pixels accepted at later edges get the new value.
- R5: Mode 4'b0001 outputs `pixData` unchanged, as red=[23:16], green=[15:8], blue=[7:0].
- R6: Mode 4'b0010 unpacks red=[15:11], green=[10:5], blue=[4:0]. A 5-bit field f widens to {f, f[4:2]} and a 6-bit field g widens to {g, g[5:4]}, so an all-ones field gives 8'hFF.
- R7: Mode 4'b0011 unpacks red=[14:10], green=[9:5], blue=[4:0], each widened as in R6. Bit 15 has no effect.
- R8: Mode 4'b1110 applies the dim transform (v -> {1'b0, v[7:1]}) to each 8-bit component of the 8:8:8 word while `blinkPhase`=1. When `blinkPhase`=0 the output equals mode 4'b0001.
- R9: Mode 4'b1111 applies the bright transform (v -> {v[6:0], 1'b1}) to each component while `blinkPhase`=1. When `blinkPhase`=0 it passes the components through.
- R10: Modes 4'b0100 (dim) and 4'b0101 (bright) apply the R8/R9 transform to `pixData[7:0]` under the same `blinkPhase` rule, then use the result as the palette index.
- R11: Any other mode code yields `rgbOut`=24'h000000 with `rgbValid`=1.
- R12: When `pixValid` is 0, `rgbValid` is 0 two edges later and `rgbOut` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Pixel word strobe |
| pixData | input | 24 | Raw pixel word |
| colorMode | input | 4 | Color mode code |
| blinkPhase | input | 1 | Blink phase; transforms act while high |
| palWrEn | input | 1 | Palette write enable |
| palWrAddr | input | 8 | Palette entry to write |
| palWrData | input | 24 | Palette color to write |
| rgbOut | output | 24 | Decoded color, red in the top byte |
| rgbValid | output | 1 | Decoded color strobe |

## Verification
The hardest case to reach is a palette write that lands on the same edge as a lookup of that same entry, followed at once by another lookup of it. Only that sequence shows the old-then-new ordering, and random traffic almost never produces it. A directed sequence forces it at one address. The random phase also sends most of its writes to a small group of addresses that lookups draw from as well, so writes often collide with reads near each other in time. The bench keeps a shadow palette that it updates only after computing that cycle's expected value.

// File: rtl/pixel_decode_pkg.sv
package pixel_decode_pkg;
  localparam int COMP_W = 8;
  localparam int RGB_W  = 3 * COMP_W;

  typedef enum logic [3:0] {
    MODE_PAL        = 4'b0000,
    MODE_RGB888     = 4'b0001,
    MODE_RGB565     = 4'b0010,
    MODE_RGB555     = 4'b0011,
    MODE_PAL_DIM    = 4'b0100,
    MODE_PAL_BRIGHT = 4'b0101,
    MODE_DIM888     = 4'b1110,
    MODE_BRIGHT888  = 4'b1111
  } colorMode_e;

  typedef enum logic [1:0] {
    FMT_888  = 2'd0,
    FMT_565  = 2'd1,
    FMT_555  = 2'd2,
    FMT_NONE = 2'd3
  } pixFmt_e;

  typedef struct packed {
    logic    load;
    logic    usePalette;
    logic    dimEn;
    logic    brightEn;
    pixFmt_e fmt;
  } decodeCtrl_t;
endpackage

// File: rtl/pixel_decode_ctrl.sv
module pixel_decode_ctrl
  import pixel_decode_pkg::*;
(
  input  logic        pixValid,
  input  logic [3:0]  colorMode,
  input  logic        blinkPhase,
  output decodeCtrl_t ctrl
);
  always_comb begin
    ctrl            = '0;
    ctrl.load       = pixValid;
    ctrl.fmt        = FMT_NONE;
    case (colorMode)
      MODE_PAL:        ctrl.usePalette = 1'b1;
      MODE_PAL_DIM:    begin ctrl.usePalette = 1'b1; ctrl.dimEn    = blinkPhase; end
      MODE_PAL_BRIGHT: begin ctrl.usePalette = 1'b1; ctrl.brightEn = blinkPhase; end
      MODE_RGB888:     ctrl.fmt = FMT_888;
      MODE_RGB565:     ctrl.fmt = FMT_565;
      MODE_RGB555:     ctrl.fmt = FMT_555;
      MODE_DIM888:     begin ctrl.fmt = FMT_888; ctrl.dimEn    = blinkPhase; end
      MODE_BRIGHT888:  begin ctrl.fmt = FMT_888; ctrl.brightEn = blinkPhase; end
      default:         ctrl.fmt = FMT_NONE;
    endcase
  end
endmodule

// File: rtl/pixel_decode_datapath.sv
module pixel_decode_datapath
  import pixel_decode_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  decodeCtrl_t       ctrl,
  input  logic [RGB_W-1:0]  pixData,
  input  logic              palWrEn,
  input  logic [IDX_W-1:0]  palWrAddr,
  input  logic [RGB_W-1:0]  palWrData,
  output logic [RGB_W-1:0]  rgbOut,
  output logic              rgbValid
);
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [7:0] widen5(input logic [4:0] f);
    return {f, f[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] g);
    return {g, g[5:4]};
  endfunction

  // Blink transform, one instance per 8-bit component
  logic [RGB_W-1:0] blinked;
  for (genvar c = 0; c < 3; c++) begin : g_blink
    logic [COMP_W-1:0] comp;
    assign comp = pixData[c*COMP_W +: COMP_W];
    always_comb begin
      if (ctrl.dimEn)
        blinked[c*COMP_W +: COMP_W] = {1'b0, comp[COMP_W-1:1]};
      else if (ctrl.brightEn)
        blinked[c*COMP_W +: COMP_W] = {comp[COMP_W-2:0], 1'b1};
      else
        blinked[c*COMP_W +: COMP_W] = comp;
    end
  end

  logic [IDX_W-1:0] palIdx;
  assign palIdx = blinked[IDX_W-1:0];

  // Direct-color expansion
  logic [RGB_W-1:0] directRgb;
  always_comb begin
    case (ctrl.fmt)
      FMT_888: directRgb = blinked;
      FMT_565: directRgb = {widen5(pixData[15:11]), widen6(pixData[10:5]), widen5(pixData[4:0])};
      FMT_555: directRgb = {widen5(pixData[14:10]), widen5(pixData[9:5]), widen5(pixData[4:0])};
      default: directRgb = '0;
    endcase
  end

  // Stage 1: synchronous palette read alongside delayed direct color
  logic [RGB_W-1:0] palMem [DEPTH];
  logic [RGB_W-1:0] palRd;
  logic             s1Valid;
  logic             s1UsePal;
  logic [RGB_W-1:0] s1Direct;

  always_ff @(posedge clk) begin
    if (palWrEn) palMem[palWrAddr] <= palWrData;
    if (ctrl.load && ctrl.usePalette) palRd <= palMem[palIdx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid  <= 1'b0;
      s1UsePal <= 1'b0;
      s1Direct <= '0;
    end else begin
      s1Valid <= ctrl.load;
      if (ctrl.load) begin
        s1UsePal <= ctrl.usePalette;
        s1Direct <= directRgb;
      end
    end
  end

  // Stage 2: output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgbValid <= 1'b0;
      rgbOut   <= '0;
    end else begin
      rgbValid <= s1Valid;
      if (s1Valid) rgbOut <= s1UsePal ? palRd : s1Direct;
    end
  end
endmodule

// File: rtl/pixel_decode.sv
module pixel_decode
  import pixel_decode_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pixValid,
  input  logic [RGB_W-1:0]  pixData,
  input  logic [3:0]        colorMode,
  input  logic              blinkPhase,
  input  logic              palWrEn,
  input  logic [IDX_W-1:0]  palWrAddr,
  input  logic [RGB_W-1:0]  palWrData,
  output logic [RGB_W-1:0]  rgbOut,
  output logic              rgbValid
);
  decodeCtrl_t ctrl;

  pixel_decode_ctrl u_ctrl (
    .pixValid   (pixValid),
    .colorMode  (colorMode),
    .blinkPhase (blinkPhase),
    .ctrl       (ctrl)
  );

  pixel_decode_datapath #(.IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .pixData   (pixData),
    .palWrEn   (palWrEn),
    .palWrAddr (palWrAddr),
    .palWrData (palWrData),
    .rgbOut    (rgbOut),
    .rgbValid  (rgbValid)
  );
endmodule

// File: rtl/pixel_decode_check.sv
module pixel_decode_check (
  input logic        clk,
  input logic        rst_n,
  input logic        pixValid,
  input logic [23:0] pixData,
  input logic [3:0]  colorMode,
  input logic        blinkPhase,
  input logic [23:0] rgbOut,
  input logic        rgbValid
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd2) cyc <= cyc + 2'd1;
  end

  always_comb begin
    if (!rst_n) assert_reset_quiet_R2: assert (!rgbValid);
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2) |-> (rgbValid == $past(pixValid, 2)));

  assert_direct_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && rgbValid && $past(colorMode, 2) == 4'b0001) |-> (rgbOut == $past(pixData, 2)));

  assert_dim_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && rgbValid && $past(colorMode, 2) == 4'b1110 && $past(blinkPhase, 2))
      |-> (!rgbOut[23] && !rgbOut[15] && !rgbOut[7]));

  assert_bright_lsb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && rgbValid && $past(colorMode, 2) == 4'b1111 && $past(blinkPhase, 2))
      |-> (rgbOut[16] && rgbOut[8] && rgbOut[0]));

  assert_reserved_black_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && rgbValid && $past(colorMode, 2) inside {4'b0110, 4'b0111, 4'b1000, 4'b1001,
      4'b1010, 4'b1011, 4'b1100, 4'b1101}) |-> (rgbOut == 24'h0));

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd2 && !rgbValid) |-> $stable(rgbOut));
endmodule

bind pixel_decode pixel_decode_check u_check (
  .clk        (clk),
  .rst_n      (rst_n),
  .pixValid   (pixValid),
  .pixData    (pixData),
  .colorMode  (colorMode),
  .blinkPhase (blinkPhase),
  .rgbOut     (rgbOut),
  .rgbValid   (rgbValid)
);

// File: tb/pixel_decode_test.sv
module pixel_decode_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pixValid = 1'b0;
  logic [23:0] pixData = '0;
  logic [3:0]  colorMode = '0;
  logic        blinkPhase = 1'b0;
  logic        palWrEn = 1'b0;
  logic [7:0]  palWrAddr = '0;
  logic [23:0] palWrData = '0;
  logic [23:0] rgbOut;
  logic        rgbValid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pixel_decode uut (.*);

  logic [23:0] shadowPal [256];
  logic        p0v = 0, p1v = 0, mv = 0;
  logic [23:0] p0d = 0, p1d = 0, md = 0;
  string       p0t = "R1", p1t = "R1", mt = "R2";

  function automatic logic [7:0] w5(input logic [4:0] f); return {f, f[4:2]}; endfunction
  function automatic logic [7:0] w6(input logic [5:0] g); return {g, g[5:4]}; endfunction
  function automatic logic [7:0] dimV(input logic [7:0] v, input logic ph);
    return ph ? (v >> 1) : v;
  endfunction
  function automatic logic [7:0] brtV(input logic [7:0] v, input logic ph);
    return ph ? {v[6:0], 1'b1} : v;
  endfunction

  function automatic logic [23:0] expect_rgb(input logic [23:0] d, input logic [3:0] m, input logic ph);
    case (m)
      4'b0000: return shadowPal[d[7:0]];
      4'b0001: return d;
      4'b0010: return {w5(d[15:11]), w6(d[10:5]), w5(d[4:0])};
      4'b0011: return {w5(d[14:10]), w5(d[9:5]), w5(d[4:0])};
      4'b0100: return shadowPal[dimV(d[7:0], ph)];
      4'b0101: return shadowPal[brtV(d[7:0], ph)];
      4'b1110: return {dimV(d[23:16], ph), dimV(d[15:8], ph), dimV(d[7:0], ph)};
      4'b1111: return {brtV(d[23:16], ph), brtV(d[15:8], ph), brtV(d[7:0], ph)};
      default: return 24'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'b0000: return "R3";
      4'b0001: return "R5";
      4'b0010: return "R6";
      4'b0011: return "R7";
      4'b0100, 4'b0101: return "R10";
      4'b1110: return "R8";
      4'b1111: return "R9";
      default: return "R11";
    endcase
  endfunction

  // One cycle: check output from two drives ago, then drive new inputs
  task automatic step(input logic v, input logic [23:0] d, input logic [3:0] m, input logic ph,
                      input logic we, input logic [7:0] wa, input logic [23:0] wd, input string note);
    @(negedge clk);
    mv = p1v;
    if (p1v) begin md = p1d; mt = p1t; end
    else mt = "R12";
    checks++;
    if (rgbValid !== mv || rgbOut !== md) begin
      fails++;
      $display("FAIL %s (R1): valid=%b rgb=%06h expected valid=%b rgb=%06h", mt, rgbValid, rgbOut, mv, md);
    end
    p1v = p0v; p1d = p0d; p1t = p0t;
    p0v = v;
    p0d = v ? expect_rgb(d, m, ph) : 24'h0;
    p0t = (note != "") ? note : tag_of(m);
    if (we) shadowPal[wa] = wd;
    pixValid = v; pixData = d; colorMode = m; blinkPhase = ph;
    palWrEn = we; palWrAddr = wa; palWrData = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    // R2: hold reset while driving traffic
    pixValid = 1'b1; pixData = 24'hFFFFFF; colorMode = 4'b0001;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rgbValid !== 1'b0 || rgbOut !== 24'h0) begin
      fails++;
      $display("FAIL R2: valid=%b rgb=%06h expected valid=0 rgb=000000", rgbValid, rgbOut);
    end
    pixValid = 1'b0; pixData = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R4: load the whole palette through the write port
    for (int i = 0; i < 256; i++)
      step(0, 0, 0, 0, 1, i[7:0], (i * 24'h010307) ^ 24'h5A3C96, "R12");

    // Directed corner cases
    step(1, 24'hABCD12, 4'b0000, 0, 0, 0, 0, "R3");     // upper bits ignored
    step(1, 24'h000012, 4'b0000, 0, 0, 0, 0, "R3");
    step(1, 24'h123456, 4'b0001, 1, 0, 0, 0, "R5");
    step(1, 24'h00FFFF, 4'b0010, 0, 0, 0, 0, "R6");     // full scale -> FFFFFF
    step(1, 24'h00F800, 4'b0010, 0, 0, 0, 0, "R6");
    step(1, 24'h0007E0, 4'b0010, 0, 0, 0, 0, "R6");
    step(1, 24'h00FFFF, 4'b0011, 0, 0, 0, 0, "R7");     // bit 15 set
    step(1, 24'h007FFF, 4'b0011, 0, 0, 0, 0, "R7");     // bit 15 clear, same result
    step(1, 24'hFF8001, 4'b1110, 1, 0, 0, 0, "R8");     // -> 7F4000
    step(1, 24'hFF8001, 4'b1110, 0, 0, 0, 0, "R8");     // passthrough
    step(1, 24'h80017F, 4'b1111, 1, 0, 0, 0, "R9");     // -> 0103FF
    step(1, 24'h80017F, 4'b1111, 0, 0, 0, 0, "R9");
    step(1, 24'h000080, 4'b0100, 1, 0, 0, 0, "R10");    // index 40
    step(1, 24'h000080, 4'b0101, 1, 0, 0, 0, "R10");    // index 01
    step(1, 24'h000080, 4'b0101, 0, 0, 0, 0, "R10");    // index 80
    step(1, 24'hFFFFFF, 4'b0111, 0, 0, 0, 0, "R11");
    step(1, 24'hFFFFFF, 4'b1010, 1, 0, 0, 0, "R11");
    step(1, 24'h000033, 4'b0000, 0, 1, 8'h33, 24'hC0FFEE, "R4"); // old value
    step(1, 24'h000033, 4'b0000, 0, 0, 0, 0, "R4");              // new value
    step(0, 24'h000033, 4'b0001, 0, 0, 0, 0, "R12");
    step(0, 24'h000000, 4'b0001, 0, 0, 0, 0, "R12");
    step(1, 24'h445566, 4'b0001, 0, 0, 0, 0, "R1");

    // Random traffic, writes focused on a small address group
    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  m;
      logic [23:0] d;
      logic [7:0]  wa;
      logic        v, we;
      m  = 4'($urandom_range(0, 15));
      d  = 24'($urandom);
      v  = ($urandom_range(0, 7) != 0);
      we = ($urandom_range(0, 3) == 0);
      wa = 8'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1) d[7:0] = 8'($urandom_range(0, 7));
      step(v, d, m, 1'($urandom), we, wa, 24'($urandom), "");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R12");
    step(0, 0, 0, 0, 0, 0, 0, "R12");
    step(0, 0, 0, 0, 0, 0, 0, "R12");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule